// File: doc/BRIEF.md
# Dual-Store Channel Register Bank

This block holds eight 8-bit output-level codes. Each code sits in two places: a fast volatile register that drives the channel output, and a slower nonvolatile shadow that keeps the value across a soft reset. A host reaches the bank through a plain parallel register bus that has an address, write data, a write strobe, a read strobe, registered read data and a busy flag.

A mode bit in a volatile control register chooses how channel writes land. With the bit clear, a write goes through to both stores and starts a modeled programming delay. With the bit set, a write touches only the volatile register, so a host can sweep output levels quickly. Reads always return the volatile copy. After every reset the bank copies the shadow into the volatile registers one channel per cycle and holds busy high while it does so. The channels form two groups of four (1–4 and 5–8). Both groups are handled the same way.

Top module: `dual_store_bank`

## Requirements
- R1: While reset is held and for exactly 8 cycles after it is released, busy is high. The control register reads 00h after reset, which selects write-through mode.
- R2: When busy falls after a reset, every channel output equals its nonvolatile value. The nonvolatile contents survive the reset.
- R3: With the mode bit at 0, an accepted write to address n (00h–07h) shows on that channel's output one cycle later and also updates its nonvolatile value.
- R4: With the mode bit at 1, an accepted write to 00h–07h updates only the volatile register. The nonvolatile value keeps its old content, which the next reset restores.
- R5: A read strobe on 00h–07h returns that channel's volatile code on rdata in the following cycle, whatever the mode bit holds.
- R6: The control register is at 08h. Its bit 7 is the mode bit and its other bits read as 0. Writing it changes no channel code and no nonvolatile value.
- R7: An accepted write-through channel write holds busy high for exactly PROG_CYCLES cycles, starting in the cycle after the write. Volatile-only writes and control writes leave busy low.
- R8: Writes presented while busy is high are ignored. This covers channels and the control register.
- R9: Reads of unmapped addresses (09h–0Fh) return 00h. Writes to them change nothing.
- R10: Address n drives output bits ch_code[8n+7:8n], channel n+1. Both groups of four use the same handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low soft reset. It does not clear the nonvolatile store |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | Restore or programming in progress |
| ch_code | output | 64 | Eight channel codes, channel 1 in the low byte |

## Verification
A channel write shows on ch_code one clock after the accepting edge. Read data appears one clock after the read strobe. Busy rises one clock after a write-through write and stays high for PROG_CYCLES samples. After reset release, busy stays high for eight samples. The bench drives each strobe for one cycle at a falling edge and samples at the next falling edge, so every result is read exactly one register stage after it was caused. Busy durations are measured by counting falling-edge samples until busy drops. Nonvolatile values cannot be read directly, so the bench makes them visible by applying a reset and comparing the restored outputs with its own model.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

  // Channel window check: addresses 0 .. nch-1 map to channels.
  function automatic bit is_chan(input int unsigned a, input int unsigned nch);
    return a < nch;
  endfunction

  // Control word as seen on a read: mode in the top bit, rest zero.
  function automatic logic [7:0] ctrl_word(input logic mode);
    return {mode, 7'b0};
  endfunction

endpackage

// File: rtl/dsb_restore_seq.sv
module dsb_restore_seq #(
  parameter int NCH = 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          restoring,
  output logic [IW-1:0] idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restoring <= 1'b1;
      idx       <= '0;
    end else if (restoring) begin
      idx <= idx + 1'b1;
      if (idx == IW'(NCH - 1)) restoring <= 1'b0;
    end
  end

endmodule

// File: rtl/dsb_nv_store.sv
module dsb_nv_store #(
  parameter int NCH         = 8,
  parameter int CW          = 8,
  parameter int PROG_CYCLES = 20,
  localparam int IW = $clog2(NCH),
  localparam int TW = $clog2(PROG_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [CW-1:0] wdat,
  input  logic [IW-1:0] ridx,
  output logic [CW-1:0] rdat,
  output logic          prog_busy
);

  logic [CW-1:0] mem [NCH];
  logic [TW-1:0] timer;

  // Array content is not touched by reset.
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              timer <= '0;
    else if (we)             timer <= TW'(PROG_CYCLES);
    else if (timer != '0)    timer <= timer - 1'b1;
  end

  assign rdat      = mem[ridx];
  assign prog_busy = (timer != '0);

endmodule

// File: rtl/dsb_vol_regs.sv
module dsb_vol_regs
  import dsb_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int CW        = 8,
  parameter int AW        = 4,
  parameter int CTRL_ADDR = 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chan_we,
  input  logic            ctrl_we,
  input  logic [AW-1:0]   addr,
  input  logic [CW-1:0]   wdata,
  input  logic            restoring,
  input  logic [IW-1:0]   rst_idx,
  input  logic [CW-1:0]   rst_dat,
  input  logic            rd_en,
  output logic            mode,
  output logic [CW-1:0]   rdata,
  output logic [NCH*CW-1:0] ch_code
);

  logic [CW-1:0] vol [NCH];
  logic [CW-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (is_chan(addr, NCH))                rd_word = vol[addr[IW-1:0]];
    else if (addr == AW'(CTRL_ADDR))       rd_word = CW'(ctrl_word(mode));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) vol[i] <= '0;
      mode  <= 1'b0;
      rdata <= '0;
    end else begin
      if (restoring)    vol[rst_idx]       <= rst_dat;
      else if (chan_we) vol[addr[IW-1:0]]  <= wdata;
      if (ctrl_we)      mode               <= wdata[CW-1];
      if (rd_en)        rdata              <= rd_word;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign ch_code[g*CW +: CW] = vol[g];
  end

endmodule

// File: rtl/dual_store_bank.sv
module dual_store_bank
  import dsb_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int CW          = 8,
  parameter int AW          = 4,
  parameter int CTRL_ADDR   = 8,
  parameter int PROG_CYCLES = 20,
  localparam int IW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [CW-1:0]     wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [CW-1:0]     rdata,
  output logic              busy,
  output logic [NCH*CW-1:0] ch_code
);

  // Named internal events
  logic          restoring;
  logic [IW-1:0] rst_idx;
  logic [CW-1:0] rst_dat;
  logic          prog_busy;
  logic          mode;
  logic          acc_wr;
  logic          chan_we;
  logic          ctrl_we;
  logic          nv_we;

  assign busy    = restoring | prog_busy;
  assign acc_wr  = wr_en & ~busy;
  assign chan_we = acc_wr & is_chan(addr, NCH);
  assign ctrl_we = acc_wr & (addr == AW'(CTRL_ADDR));
  assign nv_we   = chan_we & ~mode;

  dsb_restore_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n), .restoring(restoring), .idx(rst_idx)
  );

  dsb_nv_store #(.NCH(NCH), .CW(CW), .PROG_CYCLES(PROG_CYCLES)) u_nv (
    .clk(clk), .rst_n(rst_n), .we(nv_we), .widx(addr[IW-1:0]), .wdat(wdata),
    .ridx(rst_idx), .rdat(rst_dat), .prog_busy(prog_busy)
  );

  dsb_vol_regs #(.NCH(NCH), .CW(CW), .AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_vol (
    .clk(clk), .rst_n(rst_n), .chan_we(chan_we), .ctrl_we(ctrl_we),
    .addr(addr), .wdata(wdata), .restoring(restoring), .rst_idx(rst_idx),
    .rst_dat(rst_dat), .rd_en(rd_en), .mode(mode), .rdata(rdata),
    .ch_code(ch_code)
  );

endmodule

// File: rtl/dsb_checker.sv
module dsb_checker #(
  parameter int NCH       = 8,
  parameter int CW        = 8,
  parameter int AW        = 4,
  parameter int CTRL_ADDR = 8,
  localparam int IW = $clog2(NCH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     addr,
  input logic [CW-1:0]     wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic [CW-1:0]     rdata,
  input logic              busy,
  input logic [NCH*CW-1:0] ch_code,
  input logic              restoring,
  input logic              mode
);

  logic          wr_ok_q;
  logic [IW-1:0] widx_q;
  logic [CW-1:0] wdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ok_q <= 1'b0;
      widx_q  <= '0;
      wdat_q  <= '0;
    end else begin
      wr_ok_q <= wr_en && !busy && (addr < AW'(NCH));
      widx_q  <= addr[IW-1:0];
      wdat_q  <= wdata;
    end
  end

  AST_RESTORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> busy); // R1

  AST_CHAN_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok_q |-> ch_code[widx_q*CW +: CW] == wdat_q); // R3

  AST_VOLATILE_ONLY_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && mode && addr < AW'(NCH)) |=> !busy); // R4

  AST_CTRL_KEEPS_CHANNELS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && addr == AW'(CTRL_ADDR)) |=> $stable(ch_code)); // R6

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && !restoring) |=> ($stable(ch_code) && $stable(mode))); // R8

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > AW'(CTRL_ADDR)) |=> rdata == '0); // R9

endmodule

bind dual_store_bank dsb_checker #(
  .NCH(NCH), .CW(CW), .AW(AW), .CTRL_ADDR(CTRL_ADDR)
) u_dsb_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .busy(busy), .ch_code(ch_code),
  .restoring(restoring), .mode(mode)
);

// File: tb/dual_store_bank_bench.sv
module dual_store_bank_bench;

  localparam int NCH  = 8;
  localparam int PROG = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic        busy;
  logic [63:0] ch_code;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] vol_m [NCH];
  logic [7:0] nv_m  [NCH];
  logic       mode_m;

  dual_store_bank #(.PROG_CYCLES(PROG)) u_dual_store_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .busy(busy), .ch_code(ch_code)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] exp_read(input int a);
    if (a < NCH) return vol_m[a];
    if (a == 8)  return mode_m ? 8'h80 : 8'h00;
    return 8'h00;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    @(negedge clk); addr = 4'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input int a, output logic [7:0] d);
    @(negedge clk); addr = 4'(a); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic check_all_channels(input string req);
    for (int i = 0; i < NCH; i++) check(req, ch_code[i*8 +: 8], vol_m[i]);
  endtask

  task automatic apply_reset(input bool_chk);
    int n;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    if (bool_chk) check("R1 busy in reset", busy, 1);
    @(negedge clk); rst_n = 1'b1;
    count_busy(n);
    if (bool_chk) check("R1 restore busy length", n, NCH);
    for (int i = 0; i < NCH; i++) vol_m[i] = nv_m[i];
    mode_m = 1'b0;
  endtask

  // Model update for an attempted write made while idle
  task automatic model_write(input int a, input logic [7:0] d);
    if (a < NCH) begin
      vol_m[a] = d;
      if (!mode_m) nv_m[a] = d;
    end else if (a == 8) mode_m = d[7];
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int n;
    void'($urandom(32'd4711));
    // First reset: nonvolatile content is whatever the array held; adopt it.
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    count_busy(n);
    check("R1 first restore busy length", n, NCH);
    for (int i = 0; i < NCH; i++) begin nv_m[i] = ch_code[i*8 +: 8]; vol_m[i] = nv_m[i]; end
    mode_m = 1'b0;
    do_read(8, r); check("R1 ctrl after reset", r, 8'h00);

    // Write-through writes to every channel, distinct per group
    for (int i = 0; i < NCH; i++) begin
      do_write(i, 8'(8'h13 * (i + 1)));
      model_write(i, 8'(8'h13 * (i + 1)));
      check("R10 channel mapping", ch_code[i*8 +: 8], 8'h13 * (i + 1));
      count_busy(n);
      check("R7 program busy length", n, PROG);
    end
    check_all_channels("R3 write-through outputs");

    // Write during programming is dropped
    do_write(2, 8'hE7);
    model_write(2, 8'hE7);
    do_write(2, 8'h01);
    check("R8 write while busy ignored", ch_code[2*8 +: 8], 8'hE7);
    do_write(8, 8'h80);
    count_busy(n);
    do_read(8, r); check("R8 ctrl write while busy ignored", r, 8'h00);

    // Volatile-only mode
    do_write(8, 8'hFF); model_write(8, 8'hFF);
    check("R7 ctrl write no busy", busy, 0);
    do_read(8, r); check("R6 ctrl reads only mode bit", r, 8'h80);
    check_all_channels("R6 ctrl write keeps channels");
    do_write(3, 8'h5A); model_write(3, 8'h5A);
    check("R4 volatile-only no busy", busy, 0);
    check("R4 volatile-only output", ch_code[3*8 +: 8], 8'h5A);
    do_read(3, r); check("R5 read in mode 1", r, 8'h5A);
    do_write(8, 8'h00); model_write(8, 8'h00);
    check_all_channels("R6 mode toggle keeps channels");
    do_read(3, r); check("R5 read in mode 0", r, 8'h5A);

    // Unmapped
    do_write(12, 8'hAA);
    check_all_channels("R9 unmapped write ignored");
    do_read(8, r); check("R9 unmapped write leaves ctrl", r, 8'h00);
    do_read(12, r); check("R9 unmapped read", r, 8'h00);
    do_read(15, r); check("R9 unmapped read top", r, 8'h00);

    // Reset restores the shadow: channel 3 goes back
    apply_reset(1);
    check("R4 shadow kept old value", ch_code[3*8 +: 8], 8'h13 * 4);
    check_all_channels("R2 restore after reset");
    do_read(8, r); check("R1 ctrl after soft reset", r, 8'h00);

    // Random phase
    for (int k = 0; k < 600; k++) begin
      int op = $urandom_range(0, 9);
      int a  = $urandom_range(0, 15);
      logic [7:0] d = 8'($urandom);
      if (op < 5) begin
        do_write(a, d);
        model_write(a, d);
        if (a < NCH) check("R3 random write output", ch_code[a*8 +: 8], d);
        if (busy) begin
          if ($urandom_range(0, 3) == 0) begin
            do_write($urandom_range(0, 8), 8'($urandom));
            check_all_channels("R8 random busy write");
          end
          count_busy(n);
        end
      end else if (op < 7) begin
        do_write(8, d); model_write(8, d);
      end else begin
        do_read(a, r);
        check("R5 random read", r, exp_read(a));
      end
      if (k % 150 == 149) begin
        apply_reset(0);
        check_all_channels("R2 random restore");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule